// File: doc/BRIEF.md
# Exception Intercept Exit-Info Recorder

While a virtualized guest runs, every exception it raises is offered to this block with its vector, event type, error code and a fault address. The block looks up the vector in a 32-bit per-vector intercept mask. If the mask bit is clear, the exception is handed to the guest as usual. The block then remembers an interrupt-info word and its error code, describing the event being delivered. If the mask bit is set, the block produces a one-cycle exit strobe to the host. With the strobe it presents a 64-bit exit code, two exit-info words and the interrupt-info word that belongs in the exit report.

A separate in-event flag marks that an event delivery is in progress. The surrounding core sets this flag through an input. At exit, the flag decides whether the remembered word is reported with its valid bit (bit 31) forced to one, or whether zero is reported. Every exit clears the flag. An intercepted double fault clears the flag before the report is built, so such an exit never reports an event in delivery.

The control is a two-state machine. IDLE accepts exceptions. On an intercepted exception, IDLE moves to EXIT, and the exit outputs are loaded on that same edge. EXIT lasts exactly one cycle, drives the strobe, and always returns to IDLE.

Top module: `exc_exit_rec`

## Requirements
- R1: After synchronous active-high reset, exit_pulse is 0 and exit_code, exit_info1, exit_info2, int_info and int_err are all 0. The remembered word, the remembered error code and the in-event flag are cleared.
- R2: While guest_mode is 0, a raised exception has no effect: it causes no exit and changes no remembered information.
- R3: An accepted exception is intercepted exactly when bit [vector] of intercept_mask is 1. Vectors run from 0 to 31.
- R4: A non-intercepted accepted exception stores an interrupt-info word and stores err_code alongside it. The word holds the vector in bits [7:0] (upper three bits zero), the type in bits [10:8], err_valid in bit 11, and zeros in bits [31:12].
- R5: An intercepted exception produces exit_code = EXIT_BASE + vector, with EXIT_BASE defaulting to 0x40.
- R6: At exit, exit_info1 holds err_code zero-extended when err_valid is 1, and 0 otherwise. exit_info2 holds qual_addr only when err_valid is 1 and the vector is 14, and 0 otherwise.
- R7: At exit, if the in-event flag is set, int_info is the stored word with bit 31 set and int_err is the stored error code. Otherwise both are 0. The flag is cleared by every exit.
- R8: An intercepted vector 8 clears the in-event flag before the report is built, so its int_info and int_err are 0. The stored word itself is kept.
- R9: exit_pulse is high for exactly one cycle, in the cycle after the exception is offered, with all exit outputs already valid. An exception offered during that cycle is ignored. Exit outputs hold their values until the next exit.
- R10: in_event_set high for one cycle sets the in-event flag from the next cycle on. If an exit is taken in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| guest_mode | input | 1 | Guest is running; exceptions are ignored when low |
| exc_valid | input | 1 | An exception is offered this cycle |
| vector | input | 5 | Exception vector 0..31 |
| evt_type | input | 3 | Event type |
| err_code | input | ERR_W | Error code |
| err_valid | input | 1 | Error code is delivered |
| qual_addr | input | ADDR_W | Fault qualification address |
| intercept_mask | input | 32 | Per-vector intercept mask |
| in_event_set | input | 1 | Marks an event delivery in progress |
| exit_pulse | output | 1 | One-cycle exit strobe |
| exit_code | output | CODE_W | Exit code |
| exit_info1 | output | CODE_W | First exit-info word |
| exit_info2 | output | CODE_W | Second exit-info word |
| int_info | output | 32 | Interrupt-info word reported at exit |
| int_err | output | ERR_W | Error code reported at exit |

## Verification
The bench first plants records with non-intercepted exceptions that use different vectors, types and error-valid settings. It then reads each record back through an exit taken with the in-event flag set. A wrong bit placement in the stored word shows up as a wrong int_info value. Exits taken with the flag clear, and with an intercepted double fault, show whether the flag is cleared and whether the valid bit is forced. Page-fault exits with and without a valid error code, compared against other vectors, show when exit_info2 is loaded. The bench also offers exceptions while guest_mode is low and during the strobe cycle. A later readback of the record shows that those exceptions left nothing behind.

// File: rtl/exc_rec_pkg.sv
package exc_rec_pkg;
    localparam int VEC_W   = 5;
    localparam int NUM_VEC = 1 << VEC_W;
    localparam int TYPE_W  = 3;
    localparam int INFO_W  = 32;
    localparam int PF_VEC  = 14;
    localparam int DF_VEC  = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXIT = 1'b1
    } rec_state_e;

    function automatic logic [INFO_W-1:0] pack_info(
        input logic [VEC_W-1:0]  vec,
        input logic [TYPE_W-1:0] typ,
        input logic              errv
    );
        logic [INFO_W-1:0] w;
        w        = '0;
        w[7:0]   = {{(8-VEC_W){1'b0}}, vec};
        w[10:8]  = typ;
        w[11]    = errv;
        return w;
    endfunction
endpackage

// File: rtl/exc_rec_classify.sv
module exc_rec_classify
    import exc_rec_pkg::*;
(
    input  logic                 accept_en,
    input  logic                 guest_mode,
    input  logic                 exc_valid,
    input  logic [VEC_W-1:0]     vector,
    input  logic [TYPE_W-1:0]    evt_type,
    input  logic                 err_valid,
    input  logic [NUM_VEC-1:0]   intercept_mask,
    output logic                 hit_take,
    output logic                 rec_take,
    output logic [INFO_W-1:0]    info_word
);
    logic taken;
    logic masked;

    always_comb begin
        taken     = accept_en && guest_mode && exc_valid;
        masked    = intercept_mask[vector];
        hit_take  = taken && masked;
        rec_take  = taken && !masked;
        info_word = pack_info(vector, evt_type, err_valid);
    end
endmodule

// File: rtl/exc_rec_store.sv
module exc_rec_store
    import exc_rec_pkg::*;
#(
    parameter int ERR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_take,
    input  logic [INFO_W-1:0] info_word,
    input  logic [ERR_W-1:0]  err_code,
    input  logic              evt_set,
    input  logic              evt_clr,
    output logic [INFO_W-1:0] rec_info,
    output logic [ERR_W-1:0]  rec_err,
    output logic              in_event
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rec_info <= '0;
            rec_err  <= '0;
            in_event <= 1'b0;
        end else begin
            if (rec_take) begin
                rec_info <= info_word;
                rec_err  <= err_code;
            end
            if (evt_clr)
                in_event <= 1'b0;
            else if (evt_set)
                in_event <= 1'b1;
        end
    end

    AST_REC_RESERVED: assert property (@(posedge clk) disable iff (rst)
        rec_info[31:12] == '0); // R4
endmodule

// File: rtl/exc_rec_fsm.sv
module exc_rec_fsm
    import exc_rec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go_exit,
    output logic accept_en,
    output logic exit_pulse
);
    rec_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        accept_en  = 1'b0;
        exit_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept_en = 1'b1;
                if (go_exit)
                    state_d = ST_EXIT;
            end
            ST_EXIT: begin
                exit_pulse = 1'b1;
                state_d    = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        exit_pulse |=> !exit_pulse); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (accept_en && !go_exit) |=> !exit_pulse); // R2
endmodule

// File: rtl/exc_exit_rec.sv
module exc_exit_rec
    import exc_rec_pkg::*;
#(
    parameter int          ERR_W     = 32,
    parameter int          ADDR_W    = 64,
    parameter int          CODE_W    = 64,
    parameter logic [63:0] EXIT_BASE = 64'h40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                guest_mode,
    input  logic                exc_valid,
    input  logic [4:0]          vector,
    input  logic [2:0]          evt_type,
    input  logic [ERR_W-1:0]    err_code,
    input  logic                err_valid,
    input  logic [ADDR_W-1:0]   qual_addr,
    input  logic [31:0]         intercept_mask,
    input  logic                in_event_set,
    output logic                exit_pulse,
    output logic [CODE_W-1:0]   exit_code,
    output logic [CODE_W-1:0]   exit_info1,
    output logic [CODE_W-1:0]   exit_info2,
    output logic [31:0]         int_info,
    output logic [ERR_W-1:0]    int_err
);
    localparam int ERR_PAD  = CODE_W - ERR_W;
    localparam int ADDR_PAD = CODE_W - ADDR_W;

    logic              accept_en;
    logic              hit_take;
    logic              rec_take;
    logic [INFO_W-1:0] info_word;
    logic [INFO_W-1:0] rec_info;
    logic [ERR_W-1:0]  rec_err;
    logic              in_event;
    logic              evt_live;

    exc_rec_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .go_exit    (hit_take),
        .accept_en  (accept_en),
        .exit_pulse (exit_pulse)
    );

    exc_rec_classify u_cls (
        .accept_en      (accept_en),
        .guest_mode     (guest_mode),
        .exc_valid      (exc_valid),
        .vector         (vector),
        .evt_type       (evt_type),
        .err_valid      (err_valid),
        .intercept_mask (intercept_mask),
        .hit_take       (hit_take),
        .rec_take       (rec_take),
        .info_word      (info_word)
    );

    exc_rec_store #(.ERR_W(ERR_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .rec_take  (rec_take),
        .info_word (info_word),
        .err_code  (err_code),
        .evt_set   (in_event_set),
        .evt_clr   (hit_take),
        .rec_info  (rec_info),
        .rec_err   (rec_err),
        .in_event  (in_event)
    );

    always_comb begin
        evt_live = in_event && (vector != VEC_W'(DF_VEC));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exit_code  <= '0;
            exit_info1 <= '0;
            exit_info2 <= '0;
            int_info   <= '0;
            int_err    <= '0;
        end else if (hit_take) begin
            exit_code  <= CODE_W'(EXIT_BASE) + CODE_W'(vector);
            exit_info1 <= err_valid ? {{ERR_PAD{1'b0}}, err_code} : '0;
            exit_info2 <= (err_valid && vector == VEC_W'(PF_VEC))
                          ? {{ADDR_PAD{1'b0}}, qual_addr} : '0;
            int_info   <= evt_live ? (rec_info | 32'h8000_0000) : '0;
            int_err    <= evt_live ? rec_err : '0;
        end
    end

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        exit_pulse |-> (exit_code >= CODE_W'(EXIT_BASE) &&
                        exit_code <  CODE_W'(EXIT_BASE) + CODE_W'(NUM_VEC))); // R5
    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
        exit_pulse |-> !in_event); // R7
    AST_INFO2_PF_ONLY: assert property (@(posedge clk) disable iff (rst)
        (exit_pulse && exit_info2 != '0)
            |-> exit_code == CODE_W'(EXIT_BASE) + CODE_W'(PF_VEC)); // R6
    AST_REPORT_VALID_BIT: assert property (@(posedge clk) disable iff (rst)
        (exit_pulse && int_info != '0) |-> int_info[31]); // R7
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
        !hit_take |=> $stable(exit_code)); // R9
endmodule

// File: tb/exc_exit_rec_tb.sv
module exc_exit_rec_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        guest_mode;
    logic        exc_valid;
    logic [4:0]  vector;
    logic [2:0]  evt_type;
    logic [31:0] err_code;
    logic        err_valid;
    logic [63:0] qual_addr;
    logic [31:0] intercept_mask;
    logic        in_event_set;
    logic        exit_pulse;
    logic [63:0] exit_code, exit_info1, exit_info2;
    logic [31:0] int_info, int_err;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_exit_rec dut_i (
        .clk(clk), .rst(rst), .guest_mode(guest_mode), .exc_valid(exc_valid),
        .vector(vector), .evt_type(evt_type), .err_code(err_code),
        .err_valid(err_valid), .qual_addr(qual_addr),
        .intercept_mask(intercept_mask), .in_event_set(in_event_set),
        .exit_pulse(exit_pulse), .exit_code(exit_code), .exit_info1(exit_info1),
        .exit_info2(exit_info2), .int_info(int_info), .int_err(int_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mark_event();
        @(negedge clk) in_event_set = 1'b1;
        @(negedge clk) in_event_set = 1'b0;
    endtask

    // Offer one exception; returns at the negedge where exit_pulse would be high.
    task automatic raise(input logic [4:0] v, input logic [2:0] t,
                         input logic [31:0] e, input logic ev, input logic [63:0] q);
        @(negedge clk);
        vector = v; evt_type = t; err_code = e; err_valid = ev; qual_addr = q;
        exc_valid = 1'b1;
        @(negedge clk);
        exc_valid = 1'b0;
    endtask

    task automatic expect_exit(input string tag, input logic [63:0] code,
                               input logic [63:0] i1, input logic [63:0] i2,
                               input logic [31:0] ii, input logic [31:0] ie);
        chk({tag, " pulse"}, {63'd0, exit_pulse}, 64'd1);
        chk({tag, " code"}, exit_code, code);
        chk({tag, " info1"}, exit_info1, i1);
        chk({tag, " info2"}, exit_info2, i2);
        chk({tag, " int_info"}, {32'd0, int_info}, {32'd0, ii});
        chk({tag, " int_err"}, {32'd0, int_err}, {32'd0, ie});
        @(negedge clk);
        chk({tag, " pulse end R9"}, {63'd0, exit_pulse}, 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 pulse", {63'd0, exit_pulse}, 64'd0);
        chk("R1 code", exit_code, 64'd0);
        chk("R1 info1", exit_info1, 64'd0);
        chk("R1 info2", exit_info2, 64'd0);
        chk("R1 int_info", {32'd0, int_info}, 64'd0);
        chk("R1 int_err", {32'd0, int_err}, 64'd0);
        intercept_mask = 32'h0000_2000;
        mark_event();
        raise(5'd13, 3'd3, 32'h0, 1'b0, 64'h0);
        expect_exit("R1 cleared record", 64'h4D, 64'h0, 64'h0, 32'h8000_0000, 32'h0);
    endtask

    task automatic t_record_and_exit();
        intercept_mask = 32'h0000_2000;
        raise(5'd3, 3'd3, 32'h5, 1'b1, 64'h0);
        chk("R3 not intercepted", {63'd0, exit_pulse}, 64'd0);
        mark_event();
        raise(5'd13, 3'd3, 32'h1234, 1'b1, 64'hDEAD);
        expect_exit("R4 R5 R6 R7 record", 64'h4D, 64'h1234, 64'h0, 32'h8000_0B03, 32'h5);
        raise(5'd13, 3'd3, 32'h7, 1'b0, 64'h0);
        expect_exit("R7 flag cleared", 64'h4D, 64'h0, 64'h0, 32'h0, 32'h0);
    endtask

    task automatic t_page_fault();
        intercept_mask = 32'h0000_6000;
        raise(5'd14, 3'd3, 32'h2, 1'b1, 64'hFFFF_8000_1234_5678);
        expect_exit("R6 pf qual", 64'h4E, 64'h2, 64'hFFFF_8000_1234_5678, 32'h0, 32'h0);
        raise(5'd14, 3'd3, 32'h2, 1'b0, 64'hFFFF_8000_1234_5678);
        expect_exit("R6 pf no err", 64'h4E, 64'h0, 64'h0, 32'h0, 32'h0);
        raise(5'd13, 3'd3, 32'h9, 1'b1, 64'h1111);
        expect_exit("R6 non-pf no qual", 64'h4D, 64'h9, 64'h0, 32'h0, 32'h0);
    endtask

    task automatic t_double_fault();
        intercept_mask = 32'h0000_2100;
        raise(5'd6, 3'd3, 32'hAA, 1'b0, 64'h0);
        chk("R3 vec6 not intercepted", {63'd0, exit_pulse}, 64'd0);
        mark_event();
        raise(5'd8, 3'd3, 32'h0, 1'b1, 64'h0);
        expect_exit("R8 df", 64'h48, 64'h0, 64'h0, 32'h0, 32'h0);
        mark_event();
        raise(5'd13, 3'd3, 32'h0, 1'b0, 64'h0);
        expect_exit("R8 record kept", 64'h4D, 64'h0, 64'h0, 32'h8000_0306, 32'hAA);
    endtask

    task automatic t_no_guest();
        intercept_mask = 32'h0000_2000;
        guest_mode = 1'b0;
        raise(5'd13, 3'd3, 32'h1, 1'b1, 64'h0);
        chk("R2 no exit", {63'd0, exit_pulse}, 64'd0);
        raise(5'd2, 3'd2, 32'h77, 1'b1, 64'h0);
        chk("R2 no exit 2", {63'd0, exit_pulse}, 64'd0);
        chk("R2 outputs held", exit_code, 64'h4D);
        guest_mode = 1'b1;
        mark_event();
        raise(5'd13, 3'd3, 32'h0, 1'b0, 64'h0);
        expect_exit("R2 record untouched", 64'h4D, 64'h0, 64'h0, 32'h8000_0306, 32'hAA);
    endtask

    task automatic t_back_to_back();
        intercept_mask = 32'h0000_2000;
        @(negedge clk);
        vector = 5'd13; evt_type = 3'd3; err_code = 32'h3; err_valid = 1'b1;
        exc_valid = 1'b1;
        @(negedge clk);
        vector = 5'd5; evt_type = 3'd2; err_code = 32'h55; err_valid = 1'b1;
        chk("R9 pulse in exit", {63'd0, exit_pulse}, 64'd1);
        chk("R9 outputs valid", exit_info1, 64'h3);
        @(negedge clk);
        exc_valid = 1'b0;
        chk("R9 single pulse", {63'd0, exit_pulse}, 64'd0);
        mark_event();
        raise(5'd13, 3'd3, 32'h0, 1'b0, 64'h0);
        expect_exit("R9 ignored in exit", 64'h4D, 64'h0, 64'h0, 32'h8000_0306, 32'hAA);
    endtask

    task automatic t_edges();
        intercept_mask = 32'h8000_0001;
        raise(5'd31, 3'd3, 32'h0, 1'b0, 64'h0);
        expect_exit("R3 R5 vec31", 64'h5F, 64'h0, 64'h0, 32'h0, 32'h0);
        raise(5'd0, 3'd3, 32'h0, 1'b0, 64'h0);
        expect_exit("R3 R5 vec0", 64'h40, 64'h0, 64'h0, 32'h0, 32'h0);
        raise(5'd30, 3'd4, 32'hC, 1'b1, 64'h0);
        chk("R3 vec30 clear bit", {63'd0, exit_pulse}, 64'd0);
        mark_event();
        raise(5'd31, 3'd3, 32'h0, 1'b0, 64'h0);
        expect_exit("R4 R10 vec30 record", 64'h5F, 64'h0, 64'h0, 32'h8000_0C1E, 32'hC);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; guest_mode = 1'b1; exc_valid = 1'b0; vector = '0;
        evt_type = '0; err_code = '0; err_valid = 1'b0; qual_addr = '0;
        intercept_mask = '0; in_event_set = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_record_and_exit();
        t_page_fault();
        t_double_fault();
        t_no_guest();
        t_back_to_back();
        t_edges();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule